// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block forms a 32-bit memory address from the addressing fields of an instruction that has already been decoded. It takes an optional base value, an optional index value with a scale selector, and a displacement whose width is given by a size code. The result is the sum of base, index shifted left by the scale code, and the sign-extended displacement, modulo 2^32. Any of the three terms can be left out, so the same datapath covers these forms: direct (displacement only), indirect (base only), base plus displacement, scaled index plus displacement, and the full base plus scaled index plus displacement.

The block also forms stack addresses. A push request yields the stack pointer minus four as both the store address and the new stack pointer. A pop request yields the current stack pointer as the load address and the stack pointer plus four as the new stack pointer. The caller supplies the current stack pointer and writes the returned value back to its own register file.

A small state machine controls the registered outputs. It has two states. `ST_IDLE` is entered at reset and is the state when no result was captured on the last edge. `ST_RESULT` is the state when the last edge captured a request. The transitions are: `T_ACCEPT` from `ST_IDLE` to `ST_RESULT` on a request; `T_STREAM` from `ST_RESULT` to itself on a further request; `T_DRAIN` from `ST_RESULT` to `ST_IDLE` with no request; `T_WAIT` from `ST_IDLE` to itself with no request. `valid_o` is high exactly in `ST_RESULT`.

Top module: `agu_core`

## Requirements
- R1: After reset, `valid_o` is 0, `addr_o` is 0 and `sp_o` is 0.
- R2: `valid_o` is 1 in the cycle after each clock edge where `req_i` was 1, and 0 after each edge where `req_i` was 0. Back-to-back requests give back-to-back results.
- R3: For op code 0 (address form), `addr_o` becomes base term + scaled index term + displacement term, with the sum taken modulo 2^32.
- R4: Scale code s (0..3) multiplies the index by 2^s, so the factors are 1, 2, 4 and 8. Bits shifted past bit 31 are dropped.
- R5: Displacement size code 0 means no displacement (all `disp_i` bits ignored). Code 1 uses `disp_i[7:0]` sign-extended. Code 2 uses `disp_i[15:0]` sign-extended. Code 3 uses all 32 bits. Bits above the selected width are ignored.
- R6: When `base_en_i` is 0 the base term is 0. When `index_en_i` is 0 the index term is 0, whatever the values on `base_i`, `index_i` and `scale_i`.
- R7: For op code 1 (push), `addr_o` and `sp_o` both become `sp_i` - 4 modulo 2^32. The addressing fields have no effect.
- R8: For op code 2 (pop), `addr_o` becomes `sp_i` and `sp_o` becomes `sp_i` + 4 modulo 2^32.
- R9: For op codes 0 and 3 (3 behaves as the address form), `sp_o` becomes `sp_i` unchanged.
- R10: While `req_i` is 0, `addr_o` and `sp_o` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request strobe; all other inputs are sampled on edges where it is 1 |
| op_i | input | 2 | 0 address form, 1 push, 2 pop, 3 address form |
| base_en_i | input | 1 | Include the base term |
| base_i | input | 32 | Base value |
| index_en_i | input | 1 | Include the scaled index term |
| index_i | input | 32 | Index value |
| scale_i | input | 2 | Shift count for the index (factor 1, 2, 4, 8) |
| disp_sz_i | input | 2 | Displacement size: 0 none, 1 byte, 2 half, 3 full |
| disp_i | input | 32 | Displacement value |
| sp_i | input | 32 | Current stack pointer |
| addr_o | output | 32 | Registered effective address |
| valid_o | output | 1 | High in the cycle after an accepted request |
| sp_o | output | 32 | Registered updated stack pointer |

## Verification
The assertions assume that `req_i` is a clean level sampled at the clock edge, and that `sp_i` and `op_i` are stable through the edge where a request is taken. They also assume `req_i` is held low during reset, so that no history before reset is looked at. The bench changes every input only on the falling edge and keeps `req_i` low through reset. Its random loop mixes all op codes, all scale and size codes, and enables with full 32-bit values, so upper garbage bits and wrap-around occur often.

// File: rtl/agu_pkg.sv
package agu_pkg;

    typedef enum logic [1:0] {
        OP_EA   = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2,
        OP_EA2  = 2'd3
    } agu_op_e;

    typedef enum logic [1:0] {
        DSZ_NONE = 2'd0,
        DSZ_BYTE = 2'd1,
        DSZ_HALF = 2'd2,
        DSZ_FULL = 2'd3
    } agu_dsz_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } agu_state_e;

    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;

endpackage

// File: rtl/agu_disp_ext.sv
module agu_disp_ext
    import agu_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] raw_i,
    input  agu_dsz_e      size_i,
    output logic [AW-1:0] ext_o
);
    localparam int PAD_B = AW - BYTE_W;
    localparam int PAD_H = AW - HALF_W;

    always_comb begin
        unique case (size_i)
            DSZ_NONE: ext_o = '0;
            DSZ_BYTE: ext_o = {{PAD_B{raw_i[BYTE_W-1]}}, raw_i[BYTE_W-1:0]};
            DSZ_HALF: ext_o = {{PAD_H{raw_i[HALF_W-1]}}, raw_i[HALF_W-1:0]};
            DSZ_FULL: ext_o = raw_i;
        endcase
    end
endmodule

// File: rtl/agu_scale.sv
module agu_scale #(
    parameter int AW = 32,
    parameter int SW = 2
) (
    input  logic [AW-1:0] idx_i,
    input  logic          en_i,
    input  logic [SW-1:0] sel_i,
    output logic [AW-1:0] term_o
);
    localparam int NSC = 1 << SW;

    logic [AW-1:0] cand [NSC];

    for (genvar g = 0; g < NSC; g++) begin : g_shift
        assign cand[g] = idx_i << g;
    end

    always_comb begin
        term_o = en_i ? cand[sel_i] : '0;
    end
endmodule

// File: rtl/agu_stack.sv
module agu_stack
    import agu_pkg::*;
#(
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  logic [AW-1:0] sp_i,
    input  agu_op_e       op_i,
    output logic [AW-1:0] addr_o,
    output logic [AW-1:0] sp_next_o
);
    localparam logic [AW-1:0] STEP_V = AW'(STEP);

    logic [AW-1:0] sp_dec;
    logic [AW-1:0] sp_inc;

    assign sp_dec = sp_i - STEP_V;
    assign sp_inc = sp_i + STEP_V;

    always_comb begin
        unique case (op_i)
            OP_PUSH: begin
                addr_o    = sp_dec;
                sp_next_o = sp_dec;
            end
            OP_POP: begin
                addr_o    = sp_i;
                sp_next_o = sp_inc;
            end
            default: begin
                addr_o    = '0;
                sp_next_o = sp_i;
            end
        endcase
    end
endmodule

// File: rtl/agu_core.sv
module agu_core
    import agu_pkg::*;
#(
    parameter int AW      = 32,
    parameter int SCALE_W = 2,
    parameter int SP_STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic [1:0]    op_i,
    input  logic          base_en_i,
    input  logic [AW-1:0] base_i,
    input  logic          index_en_i,
    input  logic [AW-1:0] index_i,
    input  logic [SCALE_W-1:0] scale_i,
    input  logic [1:0]    disp_sz_i,
    input  logic [AW-1:0] disp_i,
    input  logic [AW-1:0] sp_i,
    output logic [AW-1:0] addr_o,
    output logic          valid_o,
    output logic [AW-1:0] sp_o
);
    localparam logic [AW-1:0] STEP_V = AW'(SP_STEP);

    agu_op_e    op;
    agu_dsz_e   dsz;
    agu_state_e state_q, state_d;

    logic [AW-1:0] base_term;
    logic [AW-1:0] index_term;
    logic [AW-1:0] disp_term;
    logic [AW-1:0] ea_sum;
    logic [AW-1:0] stk_addr;
    logic [AW-1:0] stk_sp;
    logic [AW-1:0] addr_d;
    logic [AW-1:0] sp_d;
    logic          is_stack;

    assign op  = agu_op_e'(op_i);
    assign dsz = agu_dsz_e'(disp_sz_i);

    agu_disp_ext #(.AW(AW)) u_disp (
        .raw_i  (disp_i),
        .size_i (dsz),
        .ext_o  (disp_term)
    );

    agu_scale #(.AW(AW), .SW(SCALE_W)) u_scale (
        .idx_i  (index_i),
        .en_i   (index_en_i),
        .sel_i  (scale_i),
        .term_o (index_term)
    );

    agu_stack #(.AW(AW), .STEP(SP_STEP)) u_stack (
        .sp_i      (sp_i),
        .op_i      (op),
        .addr_o    (stk_addr),
        .sp_next_o (stk_sp)
    );

    assign base_term = base_en_i ? base_i : '0;
    assign ea_sum    = base_term + index_term + disp_term;
    assign is_stack  = (op == OP_PUSH) || (op == OP_POP);

    always_comb begin
        addr_d = is_stack ? stk_addr : ea_sum;
        sp_d   = stk_sp;
    end

    // next-state: T_ACCEPT, T_STREAM, T_DRAIN, T_WAIT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = req_i ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = req_i ? ST_RESULT : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered data outputs, loaded on every accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_o <= '0;
            sp_o   <= '0;
        end else if (req_i) begin
            addr_o <= addr_d;
            sp_o   <= sp_d;
        end
    end

    always_comb begin
        valid_o = (state_q == ST_RESULT);
    end

    // R2: a request is followed by valid, no request by no valid
    a_r2_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> valid_o);
    a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !valid_o);

    // R7: push returns matching address and pointer, one step below input
    a_r7_push_sp: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && op_i == 2'd1) |=> (addr_o == sp_o) && (sp_o == $past(sp_i) - STEP_V));

    // R8: pop loads at the old pointer and moves it up one step
    a_r8_pop_sp: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && op_i == 2'd2) |=> (addr_o == $past(sp_i)) && (sp_o == $past(sp_i) + STEP_V));

    // R9: address forms leave the stack pointer as supplied
    a_r9_sp_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && (op_i == 2'd0 || op_i == 2'd3)) |=> sp_o == $past(sp_i));

    // R10: outputs hold without a request
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> $stable(addr_o) && $stable(sp_o));

    // R6: with every term off and no displacement the address is zero
    a_r6_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && op_i == 2'd0 && !base_en_i && !index_en_i && disp_sz_i == 2'd0) |=> addr_o == '0);

endmodule

// File: tb/agu_core_tb.sv
module agu_core_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_i;
    logic [1:0]  op_i;
    logic        base_en_i;
    logic [31:0] base_i;
    logic        index_en_i;
    logic [31:0] index_i;
    logic [1:0]  scale_i;
    logic [1:0]  disp_sz_i;
    logic [31:0] disp_i;
    logic [31:0] sp_i;
    logic [31:0] addr_o;
    logic        valid_o;
    logic [31:0] sp_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    agu_core u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .op_i       (op_i),
        .base_en_i  (base_en_i),
        .base_i     (base_i),
        .index_en_i (index_en_i),
        .index_i    (index_i),
        .scale_i    (scale_i),
        .disp_sz_i  (disp_sz_i),
        .disp_i     (disp_i),
        .sp_i       (sp_i),
        .addr_o     (addr_o),
        .valid_o    (valid_o),
        .sp_o       (sp_o)
    );

    function automatic logic [31:0] ref_disp(input logic [1:0] sz, input logic [31:0] d);
        case (sz)
            2'd0:    return 32'd0;
            2'd1:    return {{24{d[7]}}, d[7:0]};
            2'd2:    return {{16{d[15]}}, d[15:0]};
            default: return d;
        endcase
    endfunction

    function automatic logic [31:0] ref_addr(input logic [1:0] op, input logic be, input logic [31:0] b,
                                             input logic ie, input logic [31:0] x, input logic [1:0] sc,
                                             input logic [1:0] sz, input logic [31:0] d, input logic [31:0] sp);
        logic [31:0] xs;
        if (op == 2'd1) return sp - 32'd4;
        if (op == 2'd2) return sp;
        xs = x * (32'd1 << sc);
        return (be ? b : 32'd0) + (ie ? xs : 32'd0) + ref_disp(sz, d);
    endfunction

    function automatic logic [31:0] ref_sp(input logic [1:0] op, input logic [31:0] sp);
        if (op == 2'd1) return sp - 32'd4;
        if (op == 2'd2) return sp + 32'd4;
        return sp;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // caller is at a falling edge; drive, then check at the next falling edge
    task automatic issue(input string tag, input logic [1:0] op, input logic be, input logic [31:0] b,
                         input logic ie, input logic [31:0] x, input logic [1:0] sc,
                         input logic [1:0] sz, input logic [31:0] d, input logic [31:0] sp);
        req_i = 1'b1; op_i = op; base_en_i = be; base_i = b; index_en_i = ie; index_i = x;
        scale_i = sc; disp_sz_i = sz; disp_i = d; sp_i = sp;
        @(negedge clk);
        req_i = 1'b0;
        check({tag, " R2 valid"}, {31'd0, valid_o}, 32'd1);
        check({tag, " addr"}, addr_o, ref_addr(op, be, b, ie, x, sc, sz, d, sp));
        check({tag, " sp"}, sp_o, ref_sp(op, sp));
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired R2 actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] held_a, held_s;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; req_i = 1'b0; op_i = '0; base_en_i = 1'b0; base_i = '0;
        index_en_i = 1'b0; index_i = '0; scale_i = '0; disp_sz_i = '0; disp_i = '0; sp_i = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 valid", {31'd0, valid_o}, 32'd0);
        check("R1 addr", addr_o, 32'd0);
        check("R1 sp", sp_o, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 / R5 direct with full displacement
        issue("R3 direct", 2'd0, 0, 32'h1111_1111, 0, 32'h2222_2222, 2'd3, 2'd3, 32'h0000_2000, 32'h100);
        // R6 indirect: base only, index value ignored
        issue("R6 indirect", 2'd0, 1, 32'h0000_4000, 0, 32'hFFFF_FFFF, 2'd2, 2'd0, 32'hDEAD_BEEF, 32'h100);
        // R5 base plus negative byte displacement, garbage upper bits
        issue("R5 byte neg", 2'd0, 1, 32'h0000_1000, 0, 32'h0, 2'd0, 2'd1, 32'hABCD_EF80, 32'h100);
        // R5 half displacement negative
        issue("R5 half neg", 2'd0, 1, 32'h0001_0000, 0, 32'h0, 2'd0, 2'd2, 32'h1234_8000, 32'h100);
        // R4 every scale code, index plus displacement
        for (int s = 0; s < 4; s++)
            issue("R4 scale", 2'd0, 0, 32'h0, 1, 32'h0000_0013, 2'(s), 2'd1, 32'h0000_0004, 32'h100);
        // R4 / R3 full form with shifted-out bits and wrap
        issue("R4 wrap", 2'd0, 1, 32'hFFFF_FFF0, 1, 32'hF000_0003, 2'd3, 2'd3, 32'h0000_0010, 32'h100);
        // R9 op 3 behaves as address form
        issue("R9 op3", 2'd3, 1, 32'h0000_0800, 1, 32'h2, 2'd1, 2'd1, 32'h7F, 32'hCAFE_0000);
        // R7 push, fields ignored, wrap below zero
        issue("R7 push", 2'd1, 1, 32'h5555_5555, 1, 32'h7777_7777, 2'd3, 2'd3, 32'h9999_9999, 32'h0);
        // R8 pop wrapping above top
        issue("R8 pop", 2'd2, 1, 32'h5555_5555, 1, 32'h1, 2'd1, 2'd3, 32'h1, 32'hFFFF_FFFC);

        // R10 hold with no request while inputs change
        held_a = addr_o; held_s = sp_o;
        op_i = 2'd1; sp_i = 32'h1234_5678; base_en_i = 1'b1; base_i = 32'h4242_4242;
        @(negedge clk);
        check("R10 addr hold", addr_o, held_a);
        check("R10 sp hold", sp_o, held_s);
        check("R2 no valid", {31'd0, valid_o}, 32'd0);

        // random back-to-back stream
        for (int k = 0; k < 400; k++) begin
            issue("R3 rand", 2'($urandom), 1'($urandom), $urandom, 1'($urandom), $urandom,
                  2'($urandom), 2'($urandom), $urandom, $urandom);
        end

        @(negedge clk);
        check("R2 drain", {31'd0, valid_o}, 32'd0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule